// File: doc/BRIEF.md
# USB Dual-Role Host Hand-Back Sequencer

This block steps a dual-role USB controller through the return of the host role between two dual-role devices. A single role input picks the side. On the B side the block starts out hosting. On a finish request it first drops host operation for one cycle to quiet the bus. It then switches on its D+ pull-up so that it reattaches as a peripheral.

On the A side the block starts out as a powered peripheral, with VBUS on and its pull-up on, while the far end hosts. It counts consecutive idle cycles to detect a bus suspend. When suspend is seen, it removes its pull-up and waits. From there it either ends the session by cutting VBUS, or, on an attach event, takes back host operation and drives bus reset for a programmed number of cycles before it reports host mode as ready.

All pins are plain level-sensitive controls and status flags. No data stream passes through the block, so there is no valid/ready handshake. The suspend window is derived from the reference clock rate and the suspend time in microseconds, which give 3 ms at 48 MHz by default. The reset drive length is its own parameter.

Top module: `otg_role_swap`

## Requirements
- R1: A synchronous active-high `rst` returns the block to idle on the next edge, with `host_en`, `dp_pullup`, `vbus_en`, `bus_reset` and `host_ready` all low. Idle remains until `sess_start` is sampled high.
- R2: In idle, `sess_start` with `role_a`=0 (B side) gives `host_en`=1, `dp_pullup`=0 and `vbus_en`=0 from the next cycle on.
- R3: While the B side hosts, `host_done` causes one cycle with `host_en`=0 and `dp_pullup`=0, and then `dp_pullup`=1 with `host_en`=0 for good.
- R4: In idle, `sess_start` with `role_a`=1 (A side) gives `vbus_en`=1, `dp_pullup`=1 and `host_en`=0 from the next cycle on.
- R5: In the A peripheral phase, `dp_pullup` falls in the cycle after the IDLE_CYCLES-th consecutive sampled cycle of `bus_idle`=1. Any sampled `bus_idle`=0 restarts the count from zero.
- R6: After suspend, `end_session` sends the block back to idle with `vbus_en`=0 on the next cycle. It takes priority over `attach` sampled in the same cycle.
- R7: After suspend, `attach` raises `host_en` and `bus_reset` on the next cycle. `bus_reset` stays high for exactly RESET_CYCLES cycles, with `host_ready`=0 throughout.
- R8: When bus reset ends, `host_ready`=1, `host_en`=1, `vbus_en`=1 and `bus_reset`=0, and these hold until `rst`.
- R9: Inputs that do not belong to the current role or phase have no effect on the outputs. These are `host_done` on the A side; `bus_idle`, `attach` and `end_session` on the B side; `attach` and `end_session` before suspend; and every request other than `sess_start` in idle.
- R10: `role_a` is sampled only together with `sess_start` in idle. Later changes of `role_a` have no effect.
- R11: `host_en` and `dp_pullup` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (48 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| role_a | input | 1 | 1 = A-side behaviour, 0 = B-side, sampled at session start |
| sess_start | input | 1 | Begins a hand-back session from idle |
| host_done | input | 1 | B side: finish hosting |
| bus_idle | input | 1 | Bus shows no activity this cycle |
| attach | input | 1 | A side: far end attached |
| end_session | input | 1 | A side: cut VBUS after suspend and return to idle |
| host_en | output | 1 | Host operation enabled |
| dp_pullup | output | 1 | D+ pull-up enabled |
| vbus_en | output | 1 | VBUS supply enabled |
| bus_reset | output | 1 | Drive bus reset signalling |
| host_ready | output | 1 | Host mode active after reset completes |

## Verification
Every output comes straight from a single state register. Any request therefore shows up one clock edge after it is sampled. The exceptions are the B-side pull-up, which is due two edges after `host_done`, the pull-up drop, which is due on the edge of the IDLE_CYCLES-th idle sample, and `host_ready`, which is due RESET_CYCLES edges after `bus_reset` rises. The bench drives the inputs and samples the outputs on the falling edge. Its cycle model advances once per rising edge, so each comparison lands on the first cycle a result is due, and also on every cycle before it, where the old value must still hold.

// File: rtl/otg_swap_pkg.sv
package otg_swap_pkg;

  // Sequencer phases; order carries no meaning beyond encoding.
  typedef enum logic [2:0] {
    SW_IDLE    = 3'd0,
    SW_B_HOST  = 3'd1,
    SW_B_QUIET = 3'd2,
    SW_B_DEV   = 3'd3,
    SW_A_DEV   = 3'd4,
    SW_A_WAIT  = 3'd5,
    SW_A_RESET = 3'd6,
    SW_A_HOST  = 3'd7
  } swap_state_t;

  typedef struct packed {
    logic host_en;
    logic dp_pullup;
    logic vbus_en;
    logic bus_reset;
    logic host_ready;
  } swap_out_t;

endpackage

// File: rtl/otg_span_timer.sv
// Counts consecutive cycles with run high; hit marks the LIMIT-th one.
module otg_span_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic hit
);
  localparam int W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  assign hit = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || hit) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/otg_swap_fsm.sv
module otg_swap_fsm
  import otg_swap_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        role_a,
  input  logic        sess_start,
  input  logic        host_done,
  input  logic        attach,
  input  logic        end_session,
  input  logic        idle_hit,
  input  logic        reset_hit,
  output swap_state_t state
);
  swap_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      SW_IDLE:    if (sess_start) nxt = role_a ? SW_A_DEV : SW_B_HOST;
      SW_B_HOST:  if (host_done)  nxt = SW_B_QUIET;
      SW_B_QUIET: nxt = SW_B_DEV;
      SW_B_DEV:   nxt = SW_B_DEV;
      SW_A_DEV:   if (idle_hit)   nxt = SW_A_WAIT;
      SW_A_WAIT: begin
        if (end_session)  nxt = SW_IDLE;
        else if (attach)  nxt = SW_A_RESET;
      end
      SW_A_RESET: if (reset_hit)  nxt = SW_A_HOST;
      SW_A_HOST:  nxt = SW_A_HOST;
      default:    nxt = SW_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= SW_IDLE;
    else     state <= nxt;
  end
endmodule

// File: rtl/otg_role_swap.sv
module otg_role_swap
  import otg_swap_pkg::*;
#(
  parameter int CLK_HZ       = 48_000_000,
  parameter int SUSPEND_US   = 3000,
  parameter int RESET_CYCLES = 480_000
) (
  input  logic clk,
  input  logic rst,
  input  logic role_a,
  input  logic sess_start,
  input  logic host_done,
  input  logic bus_idle,
  input  logic attach,
  input  logic end_session,
  output logic host_en,
  output logic dp_pullup,
  output logic vbus_en,
  output logic bus_reset,
  output logic host_ready
);
  localparam int IDLE_CYCLES = (CLK_HZ / 1000) * SUSPEND_US / 1000;

  swap_state_t state;
  swap_out_t   outs;
  logic        idle_hit;
  logic        reset_hit;

  otg_span_timer #(.LIMIT(IDLE_CYCLES)) u_idle_tmr (
    .clk (clk),
    .rst (rst),
    .run (state == SW_A_DEV && bus_idle),
    .hit (idle_hit)
  );

  otg_span_timer #(.LIMIT(RESET_CYCLES)) u_reset_tmr (
    .clk (clk),
    .rst (rst),
    .run (state == SW_A_RESET),
    .hit (reset_hit)
  );

  otg_swap_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .role_a      (role_a),
    .sess_start  (sess_start),
    .host_done   (host_done),
    .attach      (attach),
    .end_session (end_session),
    .idle_hit    (idle_hit),
    .reset_hit   (reset_hit),
    .state       (state)
  );

  always_comb begin
    outs = '0;
    unique case (state)
      SW_B_HOST:  outs.host_en = 1'b1;
      SW_B_DEV:   outs.dp_pullup = 1'b1;
      SW_A_DEV: begin
        outs.dp_pullup = 1'b1;
        outs.vbus_en   = 1'b1;
      end
      SW_A_WAIT:  outs.vbus_en = 1'b1;
      SW_A_RESET: begin
        outs.host_en   = 1'b1;
        outs.vbus_en   = 1'b1;
        outs.bus_reset = 1'b1;
      end
      SW_A_HOST: begin
        outs.host_en    = 1'b1;
        outs.vbus_en    = 1'b1;
        outs.host_ready = 1'b1;
      end
      default: outs = '0;
    endcase
  end

  assign host_en    = outs.host_en;
  assign dp_pullup  = outs.dp_pullup;
  assign vbus_en    = outs.vbus_en;
  assign bus_reset  = outs.bus_reset;
  assign host_ready = outs.host_ready;
endmodule

// File: rtl/otg_role_swap_chk.sv
module otg_role_swap_chk #(
  parameter int RESET_CYCLES = 480_000
) (
  input logic clk,
  input logic rst,
  input logic end_session,
  input logic host_en,
  input logic dp_pullup,
  input logic vbus_en,
  input logic bus_reset,
  input logic host_ready
);
  localparam int CW = $clog2(RESET_CYCLES + 2);

  logic [CW-1:0] rlen;
  always_ff @(posedge clk) begin
    if (rst)            rlen <= '0;
    else if (bus_reset) rlen <= rlen + 1'b1;
    else                rlen <= '0;
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> !(host_en || dp_pullup || vbus_en || bus_reset || host_ready));

  assert_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(host_en && dp_pullup));

  assert_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    ($fell(host_en) && !$past(rst)) |=> dp_pullup);

  assert_power_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(vbus_en) && !$past(rst)) |-> (dp_pullup && !host_en));

  assert_vbus_off_R6: assert property (@(posedge clk) disable iff (rst)
    ($fell(vbus_en) && !$past(rst)) |-> $past(end_session));

  assert_rst_drive_R7: assert property (@(posedge clk) disable iff (rst)
    bus_reset |-> (host_en && !host_ready));

  assert_rst_len_R7: assert property (@(posedge clk) disable iff (rst)
    ($fell(bus_reset) && !$past(rst)) |-> (rlen == CW'(RESET_CYCLES)));

  assert_ready_R8: assert property (@(posedge clk) disable iff (rst)
    ($rose(host_ready) && !$past(rst)) |-> $past(bus_reset));
endmodule

bind otg_role_swap otg_role_swap_chk #(.RESET_CYCLES(RESET_CYCLES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .end_session (end_session),
  .host_en     (host_en),
  .dp_pullup   (dp_pullup),
  .vbus_en     (vbus_en),
  .bus_reset   (bus_reset),
  .host_ready  (host_ready)
);

// File: tb/otg_role_swap_bench.sv
module otg_role_swap_bench;
  localparam int CLK_HZ   = 4000;
  localparam int SUSP_US  = 3000;
  localparam int IDLE_N   = (CLK_HZ / 1000) * SUSP_US / 1000; // 12
  localparam int RESET_N  = 5;

  // Bench phase codes (own numbering)
  localparam int M_IDLE = 0, M_BH = 1, M_BQ = 2, M_BD = 3,
                 M_AD = 4, M_AW = 5, M_AR = 6, M_AH = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic role_a = 1'b0, sess_start = 1'b0, host_done = 1'b0;
  logic bus_idle = 1'b0, attach = 1'b0, end_session = 1'b0;
  logic host_en, dp_pullup, vbus_en, bus_reset, host_ready;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  int mst   = M_IDLE;
  int icnt  = 0;
  int rcnt  = 0;

  always #10 clk = ~clk; // 50 MHz

  otg_role_swap #(
    .CLK_HZ(CLK_HZ), .SUSPEND_US(SUSP_US), .RESET_CYCLES(RESET_N)
  ) u_otg_role_swap (
    .clk(clk), .rst(rst), .role_a(role_a), .sess_start(sess_start),
    .host_done(host_done), .bus_idle(bus_idle), .attach(attach),
    .end_session(end_session), .host_en(host_en), .dp_pullup(dp_pullup),
    .vbus_en(vbus_en), .bus_reset(bus_reset), .host_ready(host_ready)
  );

  // {host_en, dp_pullup, vbus_en, bus_reset, host_ready} per phase, from R1..R8
  function automatic logic [4:0] exp_out(int st);
    case (st)
      M_BH:    return 5'b10000; // R2
      M_BD:    return 5'b01000; // R3
      M_AD:    return 5'b01100; // R4
      M_AW:    return 5'b00100; // R5
      M_AR:    return 5'b10110; // R7
      M_AH:    return 5'b10101; // R8
      default: return 5'b00000; // R1, R3 quiet cycle, R6
    endcase
  endfunction

  function automatic string tag_of(int st);
    case (st)
      M_IDLE:      return "R1/R6";
      M_BH:        return "R2";
      M_BQ, M_BD:  return "R3";
      M_AD:        return "R4/R5";
      M_AW:        return "R5";
      M_AR:        return "R7";
      default:     return "R8";
    endcase
  endfunction

  // Next phase per requirements; unrelated inputs ignored (R9, R10)
  function automatic int next_st(int st, bit r, bit s, bit ra, bit hd,
                                 bit bi, bit at, bit es, int ic, int rc);
    if (r) return M_IDLE;
    case (st)
      M_IDLE: return s ? (ra ? M_AD : M_BH) : M_IDLE;
      M_BH:   return hd ? M_BQ : M_BH;
      M_BQ:   return M_BD;
      M_BD:   return M_BD;
      M_AD:   return (bi && ic == IDLE_N - 1) ? M_AW : M_AD;
      M_AW:   return es ? M_IDLE : (at ? M_AR : M_AW);
      M_AR:   return (rc == RESET_N - 1) ? M_AH : M_AR;
      default: return M_AH;
    endcase
  endfunction

  task automatic cyc(bit r, bit s, bit ra, bit hd, bit bi, bit at, bit es);
    int nst;
    rst = r; sess_start = s; role_a = ra; host_done = hd;
    bus_idle = bi; attach = at; end_session = es;
    nst = next_st(mst, r, s, ra, hd, bi, at, es, icnt, rcnt);
    if (!r && mst == M_AD && bi && nst == M_AD) icnt = icnt + 1; else icnt = 0;
    if (!r && mst == M_AR && nst == M_AR) rcnt = rcnt + 1; else rcnt = 0;
    mst = nst;
    @(negedge clk);
    if (done) return;
    tests++;
    if ({host_en, dp_pullup, vbus_en, bus_reset, host_ready} != exp_out(mst)) begin
      fails++;
      $display("[TB] FAIL %s: outputs %b expected %b", tag_of(mst),
               {host_en, dp_pullup, vbus_en, bus_reset, host_ready}, exp_out(mst));
    end
    tests++;
    if (host_en && dp_pullup) begin
      fails++;
      $display("[TB] FAIL R11: host_en&dp_pullup = 1 expected 0");
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("[TB] FAIL watchdog: cycles exhausted expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    cyc(1, 0, 0, 0, 0, 0, 0);   // R1 reset state
    cyc(1, 0, 0, 0, 0, 0, 0);
    // Directed B flow with ignored A-side inputs (R9)
    cyc(0, 1, 0, 0, 0, 0, 0);   // R2
    cyc(0, 0, 1, 0, 1, 1, 1);   // R9, R10 role change ignored
    cyc(0, 0, 0, 1, 0, 0, 0);   // R3 quiet cycle
    cyc(0, 0, 0, 0, 0, 0, 0);   // R3 pull-up on
    cyc(0, 0, 0, 0, 0, 0, 0);
    // Directed A flow: IDLE_N-1 idle, one break, then exactly IDLE_N (R5)
    cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(0, 1, 1, 0, 0, 0, 0);   // R4
    for (int k = 0; k < IDLE_N - 1; k++) cyc(0, 0, 1, 1, 1, 1, 1); // R9 hd/at/es ignored
    cyc(0, 0, 1, 0, 0, 0, 0);   // R5 restart
    for (int k = 0; k < IDLE_N; k++) cyc(0, 0, 0, 0, 1, 0, 0);     // R10 role low ignored
    cyc(0, 0, 1, 0, 1, 1, 1);   // R6 end_session beats attach
    cyc(0, 1, 1, 0, 0, 0, 0);
    for (int k = 0; k < IDLE_N; k++) cyc(0, 0, 1, 0, 1, 0, 0);
    cyc(0, 0, 1, 0, 0, 1, 0);   // R7 attach
    for (int k = 0; k < RESET_N + 3; k++) cyc(0, 0, 1, 1, 0, 1, 1); // R7, R8
    // Random trials
    for (int t = 0; t < 60; t++) begin
      cyc(1, 0, 0, 0, 0, 0, 0);
      for (int k = 0; k < 3; k++)        // R9 idle ignores requests
        cyc(0, 0, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      cyc(0, 1, 1'($urandom), 0, 0, 0, 0);
      for (int k = 0; k < 120; k++)
        cyc(0, 1'($urandom), 1'($urandom), ($urandom % 8) == 0,
            ($urandom % 16) != 0, ($urandom % 6) == 0, ($urandom % 10) == 0);
    end
    finish_run();
  end
endmodule